// File: doc/BRIEF.md
# Masked Exclusive Prefix Popcount

This block takes a vector of up to 16 one-bit elements and, for each element position, produces how many qualifying set bits sit at strictly lower positions. Element 0 therefore always receives zero when it is written. An optional per-element mask narrows both which source bits are counted and which destination elements are written. Unwritten elements pass through the prior destination value that the caller supplies. This makes the block a drop-in merge stage for a vector register write.

Two flags pick the operand variants. With the source flag clear, the source is taken as all ones, and the unmasked result becomes the index sequence 0, 1, ..., VL-1. With the mask flag clear, the mask is taken as all ones. The active length VL limits writing: elements at or above VL keep their prior values. The block accepts one operation per cycle and returns the merged result array one clock after the transfer.

Top module: `prefix_popcnt`

## Requirements
- R1: Element i of `out_cnt`, when written, equals the number of counted source bits at positions 0..i-1, so a written element 0 is 0. Element i occupies bits [i*5 +: 5], and source bit i belongs to element i.
- R2: With `use_mask`=1, a source bit at position j is counted only if `mask_bits[j]`=1.
- R3: With `use_mask`=1, every element whose mask bit is 0 outputs its slice of `prev_dst` unchanged.
- R4: With `use_src`=0, `src_bits` is ignored and every source bit counts as 1, so unmasked elements below VL read 0,1,2,...,VL-1.
- R5: With `use_mask`=0, `mask_bits` is ignored and every element is counted and written.
- R6: Elements whose index is not below `vl` output their `prev_dst` slice. `vl`=0 writes nothing, and any `vl` of 16 or more writes all 16 elements.
- R7: `in_ready` is always 1. When `in_valid`=1 at a rising edge, `out_cnt` shows the result and `out_valid`=1 after that edge. Without a transfer, `out_valid` falls to 0 and `out_cnt` holds its value.
- R8: Synchronous reset `rst`=1 clears `out_valid` to 0 and all of `out_cnt` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can take an operation (always 1) |
| src_bits | input | 16 | Source bit per element |
| mask_bits | input | 16 | Mask bit per element |
| use_src | input | 1 | 1: use `src_bits`; 0: treat source as all ones |
| use_mask | input | 1 | 1: apply `mask_bits`; 0: no masking |
| prev_dst | input | 80 | Prior destination, 5 bits per element |
| vl | input | 5 | Active vector length |
| out_valid | output | 1 | Result registered this cycle |
| out_cnt | output | 80 | Result counts, 5 bits per element |

## Verification
A wrong running-sum term in the chain shows up in the same result as a wrong count at every higher written element. A single bad carry therefore produces a visible step in the sequence one cycle after the transfer. A faulty write enable appears as a prior value where a count belongs, or the reverse, for exactly the elements tied to the bad mask or length comparison, and it appears in the next output. A stuck output register shows up as values that change while no operation is taken, or as a stale result after a new transfer.

// File: rtl/prefix_popcnt_pkg.sv
package prefix_popcnt_pkg;
  // Bits needed to hold values 0..n inclusive.
  function automatic int unsigned span_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/popcnt_operand_sel.sv
module popcnt_operand_sel #(
  parameter int N    = 16,
  parameter int VL_W = 5
) (
  input  logic [N-1:0]    src_bits,
  input  logic [N-1:0]    mask_bits,
  input  logic            use_src,
  input  logic            use_mask,
  input  logic [VL_W-1:0] vl,
  output logic [N-1:0]    contrib,
  output logic [N-1:0]    wr_en
);
  logic [N-1:0] src_eff;
  logic [N-1:0] mask_eff;

  assign src_eff  = use_src  ? src_bits  : '1;
  assign mask_eff = use_mask ? mask_bits : '1;
  assign contrib  = src_eff & mask_eff;

  for (genvar g = 0; g < N; g++) begin : g_en
    logic in_len;
    assign in_len   = ({1'b0, vl} > (VL_W + 1)'(g));
    assign wr_en[g] = mask_eff[g] & in_len;
  end
endmodule

// File: rtl/popcnt_prefix_scan.sv
module popcnt_prefix_scan #(
  parameter int N  = 16,
  parameter int CW = 5
) (
  input  logic [N-1:0]    contrib,
  output logic [N*CW-1:0] cnt_flat
);
  assign cnt_flat[CW-1:0] = '0;
  for (genvar g = 1; g < N; g++) begin : g_chain
    assign cnt_flat[g*CW +: CW] = cnt_flat[(g-1)*CW +: CW] + CW'(contrib[g-1]);
  end
endmodule

// File: rtl/popcnt_merge_reg.sv
module popcnt_merge_reg #(
  parameter int N  = 16,
  parameter int CW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [N-1:0]    wr_en,
  input  logic [N*CW-1:0] cnt_flat,
  input  logic [N*CW-1:0] prev_flat,
  output logic [N*CW-1:0] out_flat,
  output logic            out_valid
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= load;
  end

  for (genvar g = 0; g < N; g++) begin : g_elem
    always_ff @(posedge clk) begin
      if (rst)
        out_flat[g*CW +: CW] <= '0;
      else if (load)
        out_flat[g*CW +: CW] <= wr_en[g] ? cnt_flat[g*CW +: CW] : prev_flat[g*CW +: CW];
    end

    // R3 / R6: unwritten element carries the prior value
    a_r3_keep_prior: assert property (@(posedge clk) disable iff (rst)
      (load && !wr_en[g]) |=> (out_flat[g*CW +: CW] == $past(prev_flat[g*CW +: CW])));
  end

  a_r1_first_zero: assert property (@(posedge clk) disable iff (rst)
    (load && wr_en[0]) |=> (out_flat[CW-1:0] == '0));
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    load |=> out_valid);
  a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
    !load |=> !out_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(out_flat));
endmodule

// File: rtl/prefix_popcnt.sv
module prefix_popcnt
  import prefix_popcnt_pkg::*;
#(
  parameter int N    = 16,
  parameter int CW   = span_bits(N),
  parameter int VL_W = span_bits(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [N-1:0]    src_bits,
  input  logic [N-1:0]    mask_bits,
  input  logic            use_src,
  input  logic            use_mask,
  input  logic [N*CW-1:0] prev_dst,
  input  logic [VL_W-1:0] vl,
  output logic            out_valid,
  output logic [N*CW-1:0] out_cnt
);
  logic [N-1:0]    contrib;
  logic [N-1:0]    wr_en;
  logic [N*CW-1:0] cnt_flat;
  logic            load;

  assign in_ready = 1'b1;
  assign load     = in_valid & in_ready;

  popcnt_operand_sel #(.N(N), .VL_W(VL_W)) i_sel (
    .src_bits (src_bits),
    .mask_bits(mask_bits),
    .use_src  (use_src),
    .use_mask (use_mask),
    .vl       (vl),
    .contrib  (contrib),
    .wr_en    (wr_en)
  );

  popcnt_prefix_scan #(.N(N), .CW(CW)) i_scan (
    .contrib (contrib),
    .cnt_flat(cnt_flat)
  );

  popcnt_merge_reg #(.N(N), .CW(CW)) i_merge (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .wr_en    (wr_en),
    .cnt_flat (cnt_flat),
    .prev_flat(prev_dst),
    .out_flat (out_cnt),
    .out_valid(out_valid)
  );

  // R4: all-ones source without a mask gives the index sequence
  for (genvar g = 0; g < N; g++) begin : g_iota_chk
    a_r4_index_seq: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !use_src && !use_mask && ({1'b0, vl} > (VL_W + 1)'(g)))
        |=> (out_cnt[g*CW +: CW] == CW'(g)));
  end
endmodule

// File: tb/test_prefix_popcnt.sv
`timescale 1ns/1ps
module test_prefix_popcnt;
  localparam int N  = 16;
  localparam int CW = 5;
  localparam int NV = 11;

  // {src[15:0], mask[15:0], use_src, use_mask, vl[4:0]}
  localparam logic [38:0] VEC [NV] = '{
    {16'h0091, 16'hFFFF, 1'b1, 1'b0, 5'd8 },  // R1
    {16'h0091, 16'h00EB, 1'b1, 1'b1, 5'd8 },  // R2 R3
    {16'h0000, 16'h0000, 1'b0, 1'b0, 5'd16},  // R4
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 5'd16},  // R1
    {16'hA5A5, 16'h0F0F, 1'b1, 1'b1, 5'd16},  // R2 R3
    {16'h1234, 16'hFFFF, 1'b1, 1'b0, 5'd5 },  // R6
    {16'h0000, 16'h5555, 1'b0, 1'b1, 5'd12},  // R4 R2
    {16'hBEEF, 16'hFFFF, 1'b1, 1'b0, 5'd0 },  // R6 zero length
    {16'hBEEF, 16'h8001, 1'b1, 1'b1, 5'd31},  // R6 clamp
    {16'hFFFF, 16'h0000, 1'b1, 1'b1, 5'd16},  // R3 nothing written
    {16'h00FF, 16'h0000, 1'b1, 1'b0, 5'd16}   // R5 mask ignored
  };

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic            in_ready;
  logic [N-1:0]    src_bits;
  logic [N-1:0]    mask_bits;
  logic            use_src;
  logic            use_mask;
  logic [N*CW-1:0] prev_dst;
  logic [4:0]      vl;
  logic            out_valid;
  logic [N*CW-1:0] out_cnt;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  prefix_popcnt i_prefix_popcnt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_bits(src_bits), .mask_bits(mask_bits), .use_src(use_src),
    .use_mask(use_mask), .prev_dst(prev_dst), .vl(vl),
    .out_valid(out_valid), .out_cnt(out_cnt)
  );

  function automatic logic [N*CW-1:0] model(input logic [38:0] v, input logic [N*CW-1:0] p);
    logic [N*CW-1:0] r;
    int cnt = 0;
    int len = int'(v[4:0]);
    for (int i = 0; i < N; i++) begin
      logic s = v[6] ? v[23+i] : 1'b1;
      logic m = v[5] ? v[7+i]  : 1'b1;
      r[i*CW +: CW] = (m && i < len) ? CW'(cnt) : p[i*CW +: CW];
      if (s && m) cnt++;
    end
    return r;
  endfunction

  function automatic logic [N*CW-1:0] prev_pat(input int k);
    logic [N*CW-1:0] p;
    for (int i = 0; i < N; i++) p[i*CW +: CW] = CW'((i * 7 + k * 3 + 1) % 32);
    return p;
  endfunction

  task automatic check(input string req, input logic ok, input logic [N*CW-1:0] act,
                       input logic [N*CW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (valid=%b)", req, act, exp, out_valid);
    end
  endtask

  // Drive one operation; sample one cycle later at the falling edge.
  task automatic apply(input logic [38:0] v, input logic [N*CW-1:0] p);
    @(negedge clk);
    src_bits  = v[38:23];
    mask_bits = v[22:7];
    use_src   = v[6];
    use_mask  = v[5];
    vl        = v[4:0];
    prev_dst  = p;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N*CW-1:0] p;
    logic [N*CW-1:0] e;
    logic [N*CW-1:0] held;
    rst = 1'b1; in_valid = 1'b0; src_bits = '0; mask_bits = '0;
    use_src = 1'b0; use_mask = 1'b0; prev_dst = '1; vl = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", (out_valid === 1'b0) && (out_cnt === '0), out_cnt, '0);
    rst = 1'b0;

    // Table walk
    for (int k = 0; k < NV; k++) begin
      p = prev_pat(k);
      e = model(VEC[k], p);
      apply(VEC[k], p);
      check("R1-table", (out_valid === 1'b1) && (out_cnt === e), out_cnt, e);
    end

    // R1 explicit unmasked example
    p = '0;
    p[39:0] = {5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9};
    apply({16'h0091, 16'h0000, 1'b1, 1'b0, 5'd8}, p);
    e = p;
    e[39:0] = {5'd2, 5'd2, 5'd2, 5'd1, 5'd1, 5'd1, 5'd1, 5'd0};
    check("R1", out_cnt === e, out_cnt, e);

    // R2 R3 explicit masked example
    apply({16'h0091, 16'h00EB, 1'b1, 1'b1, 5'd8}, p);
    e = p;
    e[39:0] = {5'd1, 5'd1, 5'd1, 5'd5, 5'd1, 5'd7, 5'd1, 5'd0};
    check("R3", out_cnt === e, out_cnt, e);

    // R4 index sequence, src_bits content must not matter
    apply({16'h0000, 16'h0000, 1'b0, 1'b0, 5'd16}, '0);
    e = '0;
    for (int i = 0; i < N; i++) e[i*CW +: CW] = CW'(i);
    check("R4", out_cnt === e, out_cnt, e);
    apply({16'h1357, 16'h0000, 1'b0, 1'b0, 5'd16}, '1);
    check("R4", out_cnt === e, out_cnt, e);

    // R7 hold with no transfer while inputs move
    held = out_cnt;
    src_bits = 16'hFFFF; prev_dst = prev_pat(5); vl = 5'd3; use_mask = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", (out_valid === 1'b0) && (out_cnt === held), out_cnt, held);

    // R7 back-to-back transfers
    @(negedge clk);
    src_bits = 16'h0003; mask_bits = '0; use_src = 1'b1; use_mask = 1'b0;
    vl = 5'd4; prev_dst = '0; in_valid = 1'b1;
    @(negedge clk);
    e = '0;
    e[19:0] = {5'd2, 5'd2, 5'd1, 5'd0};
    check("R7", (out_valid === 1'b1) && (out_cnt === e), out_cnt, e);
    src_bits = 16'h0000;
    @(negedge clk);
    in_valid = 1'b0;
    e = '0;
    check("R7", (out_valid === 1'b1) && (out_cnt === e), out_cnt, e);

    // R8 reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8", (out_valid === 1'b0) && (out_cnt === '0), out_cnt, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule